// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns a pair of quadrature phase signals into a 32-bit position count, keeps a revolution count beside it, and offers the whole state through a small word-wide register port. The phase, index and home inputs arrive already synchronised and filtered. Each sample is compared with the one before it. A legal single-phase transition moves the position by one step, and a transition of both phases in the same sample is reported rather than counted. A single-phase count mode uses phase A as a clock and phase B as the direction.

The position can be reloaded from an initial value in three ways: by a software command, by a chosen edge of the index input, or by a chosen edge of the home input. In modulo mode the count stays inside the range from the initial value to the modulus and wraps at both ends. The revolution counter steps either on index edges or on those wraps. Reading the upper position half takes a snapshot of the position and the revolution count, so a multi-word read stays coherent. Sticky event flags, each with its own enable, drive one combined interrupt line. A position-match pin follows either equality with a compare value or a read of a counter register.

The register port is a plain single-cycle read/write port with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` is combinational and valid in the same cycle as `reg_rd`.

Top module: `qd_position_counter`

## Requirements
- R1: After reset the position and revolution counts read 0, all flags read 0, `irq` is low, and the compare value reads all ones (address 12 returns 0xFFFF).
- R2: Reading {A,B} as a pair, the sequence 00→10→11→01→00 adds 1 per transition and the reverse order subtracts 1. Setting CFG bit 0 (reverse) swaps the two directions.
- R3: When A and B both change in one sample, FLAGS bit 4 is set and the position does not change.
- R4: With CFG bit 1 set (single-phase), each rising edge of A adds 1 when B is 0 and subtracts 1 when B is 1. Falling edges of A and any change of B have no effect on the position.
- R5: Writing CFG with bit 12 set loads the initial value (addresses 10/11) into the position. Bit 12 always reads back as 0.
- R6: Index is enabled by CFG bit 2, its edge is chosen by bit 3 (1 = falling), and its load enable is bit 6. Home uses bits 4, 5 and 7 in the same way. The selected edge sets the index flag (FLAGS bit 1) or the home flag (FLAGS bit 0), and loads the initial value when the load enable is set. The edge that is not selected sets nothing.
- R7: With CFG bit 8 (modulo) set, a step up from the modulus (addresses 14/15) goes to the initial value and sets FLAGS bit 5. A step down from the initial value goes to the modulus and sets FLAGS bit 6.
- R8: The revolution counter (address 6) steps on a modulo wrap when CFG bit 9 is set: +1 on roll-over, −1 on roll-under. When bit 9 is clear it steps on an enabled index edge, by +1 if the last step was up and by −1 otherwise.
- R9: A read of address 4 returns the live upper position half and copies the position and revolution count into hold registers (addresses 7, 8, 9). Address 5 returns the lower half from that hold copy.
- R10: With CFG bit 10 clear, `pos_match` is high while the position equals the compare value (addresses 12/13), and FLAGS bit 3 is set. With bit 10 set, `pos_match` is high for one cycle after any read of address 4, 5 or 6.
- R11: Flags stay set until a 1 is written to their bit at address 1. `irq` is the OR of FLAGS[6:0] ANDed with the enables at address 2.
- R12: With CFG bit 11 set, FLAGS bit 2 is set when no position step occurs for the number of clocks held at address 3.
- R13: FLAGS bit 7 is read-only and shows the direction of the last step (1 = up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qa | input | 1 | Phase A, synchronised |
| qb | input | 1 | Phase B, synchronised |
| qidx | input | 1 | Index input, synchronised |
| qhome | input | 1 | Home input, synchronised |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational |
| pos_match | output | 1 | Compare match, or pulse after a counter read |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default REG_W of 16, so the position is 32 bits and the half-word split, the sign wrap to 0xFFFFFFFF and the hold coherence of the upper and lower halves are all seen at their real width. It programs a modulus of 3 and a watchdog limit of 10 clocks at run time. This brings roll-over, roll-under, the revolution step on a wrap and the watchdog timeout within a few dozen cycles. The compare value is first left at its reset value, so walking the count below zero also exercises the equality path.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [3:0] {
    A_CFG     = 4'd0,
    A_FLAGS   = 4'd1,
    A_IRQEN   = 4'd2,
    A_WDOG    = 4'd3,
    A_POS_HI  = 4'd4,
    A_POS_LO  = 4'd5,
    A_REV     = 4'd6,
    A_HPOS_HI = 4'd7,
    A_HPOS_LO = 4'd8,
    A_HREV    = 4'd9,
    A_INIT_HI = 4'd10,
    A_INIT_LO = 4'd11,
    A_CMP_HI  = 4'd12,
    A_CMP_LO  = 4'd13,
    A_MOD_HI  = 4'd14,
    A_MOD_LO  = 4'd15
  } qd_addr_e;

  // configuration bit positions
  localparam int C_REV       = 0;
  localparam int C_SINGLE    = 1;
  localparam int C_IDX_EN    = 2;
  localparam int C_IDX_FALL  = 3;
  localparam int C_HOME_EN   = 4;
  localparam int C_HOME_FALL = 5;
  localparam int C_IDX_LOAD  = 6;
  localparam int C_HOME_LOAD = 7;
  localparam int C_MOD_EN    = 8;
  localparam int C_REV_WRAP  = 9;
  localparam int C_MATCH_RD  = 10;
  localparam int C_WDOG_EN   = 11;
  localparam int C_SW_LOAD   = 12;
  localparam int CFG_W       = 12;

  // flag bit positions
  localparam int F_HOME  = 0;
  localparam int F_IDX   = 1;
  localparam int F_WDOG  = 2;
  localparam int F_CMP   = 3;
  localparam int F_SIMUL = 4;
  localparam int F_ROVR  = 5;
  localparam int F_RUND  = 6;
  localparam int NFLAG   = 7;
endpackage

// File: rtl/qd_phase_decode.sv
module qd_phase_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic single_mode,
  input  logic reverse,
  output logic step_up,
  output logic step_dn,
  output logic simul
);
  logic a_q, b_q, armed_q;
  logic da, db, fire, fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      a_q     <= a;
      b_q     <= b;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    da = a ^ a_q;
    db = b ^ b_q;
    if (single_mode) begin
      fire  = da & a;
      fwd   = ~b;
      simul = 1'b0;
    end else begin
      fire  = da ^ db;
      fwd   = a ^ b_q;
      simul = armed_q & da & db;
    end
    step_up = armed_q & fire & (fwd ^ reverse);
    step_dn = armed_q & fire & ~(fwd ^ reverse);
  end
endmodule

// File: rtl/qd_edge_sel.sv
module qd_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic enable,
  input  logic on_fall,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign hit = enable & (on_fall ? (prev_q & ~sig) : (~prev_q & sig));
endmodule

// File: rtl/qd_pos_core.sv
module qd_pos_core #(
  parameter int POS_W = 32,
  parameter int REV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             load,
  input  logic [POS_W-1:0] init_val,
  input  logic [POS_W-1:0] mod_val,
  input  logic             mod_en,
  input  logic             rev_on_wrap,
  input  logic             idx_hit,
  output logic [POS_W-1:0] pos,
  output logic [REV_W-1:0] rev,
  output logic             dir_up,
  output logic             roll_over,
  output logic             roll_under
);
  logic at_mod, at_init;

  assign at_mod     = (pos == mod_val);
  assign at_init    = (pos == init_val);
  assign roll_over  = mod_en & up & ~load & at_mod;
  assign roll_under = mod_en & dn & ~load & at_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      rev    <= '0;
      dir_up <= 1'b0;
    end else begin
      if (load)            pos <= init_val;
      else if (roll_over)  pos <= init_val;
      else if (roll_under) pos <= mod_val;
      else if (up)         pos <= pos + 1'b1;
      else if (dn)         pos <= pos - 1'b1;

      if (rev_on_wrap) begin
        if (roll_over)       rev <= rev + 1'b1;
        else if (roll_under) rev <= rev - 1'b1;
      end else if (idx_hit) begin
        rev <= dir_up ? rev + 1'b1 : rev - 1'b1;
      end

      if (up)      dir_up <= 1'b1;
      else if (dn) dir_up <= 1'b0;
    end
  end

  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn && !load) |=> $stable(pos)); // R2
  AST_WRAP_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    roll_over |=> (pos == $past(init_val))); // R7
  AST_UNDER_TO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    roll_under |=> (pos == $past(mod_val))); // R7
endmodule

// File: rtl/qd_position_counter.sv
module qd_position_counter #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qa,
  input  logic             qb,
  input  logic             qidx,
  input  logic             qhome,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             pos_match,
  output logic             irq
);
  import qd_pkg::*;
  localparam int POS_W = 2 * REG_W;

  logic [CFG_W-1:0] cfg_q;
  logic [NFLAG-1:0] flags_q, irq_en_q, flag_set, flag_clr;
  logic [REG_W-1:0] wdog_lim_q, wd_cnt_q, rev, hold_rev_q;
  logic [POS_W-1:0] init_q, cmp_q, mod_q, pos, hold_pos_q;
  logic             step_up, step_dn, simul, idx_hit, home_hit;
  logic             dir_up, roll_over, roll_under;
  logic             sw_load, load, step, wd_fire, rd_pulse_q, cnt_rd;
  qd_addr_e         addr;

  assign addr = qd_addr_e'(reg_addr);

  qd_phase_decode u_phase (
    .clk(clk), .rst_n(rst_n), .a(qa), .b(qb),
    .single_mode(cfg_q[C_SINGLE]), .reverse(cfg_q[C_REV]),
    .step_up(step_up), .step_dn(step_dn), .simul(simul)
  );

  qd_edge_sel u_idx (
    .clk(clk), .rst_n(rst_n), .sig(qidx), .enable(cfg_q[C_IDX_EN]),
    .on_fall(cfg_q[C_IDX_FALL]), .hit(idx_hit)
  );

  qd_edge_sel u_home (
    .clk(clk), .rst_n(rst_n), .sig(qhome), .enable(cfg_q[C_HOME_EN]),
    .on_fall(cfg_q[C_HOME_FALL]), .hit(home_hit)
  );

  assign sw_load = reg_wr && (addr == A_CFG) && reg_wdata[C_SW_LOAD];
  assign load    = sw_load | (idx_hit & cfg_q[C_IDX_LOAD]) | (home_hit & cfg_q[C_HOME_LOAD]);

  qd_pos_core #(.POS_W(POS_W), .REV_W(REG_W)) u_core (
    .clk(clk), .rst_n(rst_n), .up(step_up), .dn(step_dn), .load(load),
    .init_val(init_q), .mod_val(mod_q), .mod_en(cfg_q[C_MOD_EN]),
    .rev_on_wrap(cfg_q[C_REV_WRAP]), .idx_hit(idx_hit),
    .pos(pos), .rev(rev), .dir_up(dir_up),
    .roll_over(roll_over), .roll_under(roll_under)
  );

  assign step    = step_up | step_dn;
  assign wd_fire = cfg_q[C_WDOG_EN] & ~step & (wdog_lim_q != '0) &
                   (wd_cnt_q == wdog_lim_q - 1'b1);
  assign cnt_rd  = reg_rd && (addr == A_POS_HI || addr == A_POS_LO || addr == A_REV);

  always_comb begin
    flag_set         = '0;
    flag_set[F_HOME] = home_hit;
    flag_set[F_IDX]  = idx_hit;
    flag_set[F_WDOG] = wd_fire;
    flag_set[F_CMP]  = (pos == cmp_q);
    flag_set[F_SIMUL]= simul;
    flag_set[F_ROVR] = roll_over;
    flag_set[F_RUND] = roll_under;
    flag_clr = (reg_wr && addr == A_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      irq_en_q   <= '0;
      wdog_lim_q <= '0;
      init_q     <= '0;
      cmp_q      <= '1;
      mod_q      <= '0;
      flags_q    <= '0;
      hold_pos_q <= '0;
      hold_rev_q <= '0;
      wd_cnt_q   <= '0;
      rd_pulse_q <= 1'b0;
    end else begin
      flags_q    <= (flags_q & ~flag_clr) | flag_set;
      rd_pulse_q <= cnt_rd;
      if (!cfg_q[C_WDOG_EN] || step || wd_fire) wd_cnt_q <= '0;
      else                                     wd_cnt_q <= wd_cnt_q + 1'b1;
      if (reg_rd && addr == A_POS_HI) begin
        hold_pos_q <= pos;
        hold_rev_q <= rev;
      end
      if (reg_wr) begin
        case (addr)
          A_CFG:     cfg_q <= reg_wdata[CFG_W-1:0];
          A_IRQEN:   irq_en_q <= reg_wdata[NFLAG-1:0];
          A_WDOG:    wdog_lim_q <= reg_wdata;
          A_INIT_HI: init_q[POS_W-1:REG_W] <= reg_wdata;
          A_INIT_LO: init_q[REG_W-1:0] <= reg_wdata;
          A_CMP_HI:  cmp_q[POS_W-1:REG_W] <= reg_wdata;
          A_CMP_LO:  cmp_q[REG_W-1:0] <= reg_wdata;
          A_MOD_HI:  mod_q[POS_W-1:REG_W] <= reg_wdata;
          A_MOD_LO:  mod_q[REG_W-1:0] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CFG:     reg_rdata = REG_W'(cfg_q);
      A_FLAGS:   reg_rdata = REG_W'({dir_up, flags_q});
      A_IRQEN:   reg_rdata = REG_W'(irq_en_q);
      A_WDOG:    reg_rdata = wdog_lim_q;
      A_POS_HI:  reg_rdata = pos[POS_W-1:REG_W];
      A_POS_LO:  reg_rdata = hold_pos_q[REG_W-1:0];
      A_REV:     reg_rdata = rev;
      A_HPOS_HI: reg_rdata = hold_pos_q[POS_W-1:REG_W];
      A_HPOS_LO: reg_rdata = hold_pos_q[REG_W-1:0];
      A_HREV:    reg_rdata = hold_rev_q;
      A_INIT_HI: reg_rdata = init_q[POS_W-1:REG_W];
      A_INIT_LO: reg_rdata = init_q[REG_W-1:0];
      A_CMP_HI:  reg_rdata = cmp_q[POS_W-1:REG_W];
      A_CMP_LO:  reg_rdata = cmp_q[REG_W-1:0];
      A_MOD_HI:  reg_rdata = mod_q[POS_W-1:REG_W];
      default:   reg_rdata = mod_q[REG_W-1:0];
    endcase
  end

  assign pos_match = cfg_q[C_MATCH_RD] ? rd_pulse_q : (pos == cmp_q);
  assign irq       = |(flags_q & irq_en_q);

  AST_SIMUL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (simul && !load) |=> (pos == $past(pos))); // R3
  AST_HOLD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 4'd4) |=> (hold_pos_q == $past(pos))); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'd1) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R11
  AST_WDOG_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[C_WDOG_EN] |=> !(flags_q[F_WDOG] && !$past(flags_q[F_WDOG]))); // R12
endmodule

// File: tb/tb_qd_position_counter.sv
module tb_qd_position_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qa = 1'b0, qb = 1'b0, qidx = 1'b0, qhome = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pos_match, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] gs = 2'd0;

  always #5 clk = ~clk;

  qd_position_counter #(.REG_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb), .qidx(qidx), .qhome(qhome),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pos_match(pos_match), .irq(irq)
  );

  // {qa, qb, expected position}
  localparam logic [33:0] VEC [10] = '{
    {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
    {2'b01, 32'd3}, {2'b11, 32'd2}, {2'b10, 32'd1}, {2'b00, 32'd0},
    {2'b01, 32'hFFFF_FFFF}, {2'b00, 32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #2 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_pos(output logic [31:0] v);
    logic [15:0] hi, lo;
    rd(4'd4, hi);
    rd(4'd5, lo);
    v = {hi, lo};
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic qstep(input bit up);
    @(negedge clk);
    gs = up ? gs + 2'd1 : gs - 2'd1;
    case (gs)
      2'd0: {qa, qb} = 2'b00;
      2'd1: {qa, qb} = 2'b10;
      2'd2: {qa, qb} = 2'b11;
      default: {qa, qb} = 2'b01;
    endcase
    settle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_pos(p);            check("R1 pos", p, 0);
    rd(4'd6, v);          check("R1 rev", v, 0);
    rd(4'd1, v);          check("R1 flags", v, 0);
    rd(4'd12, v);         check("R1 cmp", v, 16'hFFFF);
    check("R1 irq", irq, 0);

    // R2 table walk
    foreach (VEC[i]) begin
      @(negedge clk); {qa, qb} = VEC[i][33:32];
      settle();
      rd_pos(p);
      check("R2 walk", p, VEC[i][31:0]);
    end
    gs = 2'd0;

    // R13 direction
    rd(4'd1, v);          check("R13 dir up", v[7], 1);
    qstep(0);
    rd(4'd1, v);          check("R13 dir down", v[7], 0);
    rd_pos(p);            check("R2 down", p, 32'hFFFF_FFFF);
    qstep(1);

    // R2 reverse
    wr(4'd0, 16'h0001);
    qstep(1);
    rd_pos(p);            check("R2 reverse", p, 32'hFFFF_FFFF);
    qstep(0);
    wr(4'd0, 16'h0000);

    // R3 simultaneous change
    wr(4'd1, 16'h007F);
    @(negedge clk); {qa, qb} = 2'b11; settle();
    rd_pos(p);            check("R3 no count", p, 0);
    rd(4'd1, v);          check("R3 flag", v[4], 1);
    @(negedge clk); {qa, qb} = 2'b00; settle();
    wr(4'd1, 16'h0010);
    rd(4'd1, v);          check("R11 w1c", v[4], 0);

    // R4 single phase
    wr(4'd0, 16'h0002);
    @(negedge clk); qa = 1'b1; settle();
    rd_pos(p);            check("R4 A rise B0", p, 1);
    @(negedge clk); qa = 1'b0; settle();
    @(negedge clk); qb = 1'b1; settle();
    rd_pos(p);            check("R4 B ignored", p, 1);
    @(negedge clk); qa = 1'b1; settle();
    rd_pos(p);            check("R4 A rise B1", p, 0);
    @(negedge clk); qa = 1'b0; settle();
    @(negedge clk); qb = 1'b0; settle();
    wr(4'd0, 16'h0000);
    gs = 2'd0;

    // R5 software load
    wr(4'd10, 16'h0001);
    wr(4'd11, 16'h0005);
    wr(4'd0, 16'h1000);
    rd_pos(p);            check("R5 load", p, 32'h0001_0005);
    rd(4'd0, v);          check("R5 self clear", v[12], 0);

    // R9 hold coherence
    rd(4'd4, v);          check("R9 hi", v, 16'h0001);
    qstep(1);
    rd(4'd5, v);          check("R9 lo held", v, 16'h0005);
    rd(4'd8, v);          check("R9 hold lo", v, 16'h0005);
    rd_pos(p);            check("R9 fresh", p, 32'h0001_0006);

    // R6 index, R8 revolution on index
    wr(4'd0, 16'h0044);
    wr(4'd1, 16'h007F);
    @(negedge clk); qidx = 1'b1; settle();
    rd_pos(p);            check("R6 index load", p, 32'h0001_0005);
    rd(4'd1, v);          check("R6 index flag", v[1], 1);
    rd(4'd6, v);          check("R8 rev index", v, 1);
    wr(4'd1, 16'h007F);
    @(negedge clk); qidx = 1'b0; settle();
    rd(4'd1, v);          check("R6 wrong edge", v[1], 0);

    // R6 home falling, no load
    wr(4'd0, 16'h0030);
    @(negedge clk); qhome = 1'b1; settle();
    rd(4'd1, v);          check("R6 home rise ignored", v[0], 0);
    @(negedge clk); qhome = 1'b0; settle();
    rd(4'd1, v);          check("R6 home fall", v[0], 1);
    rd_pos(p);            check("R6 home no load", p, 32'h0001_0005);

    // R7 modulo, R8 revolution on wrap
    wr(4'd10, 16'h0000);
    wr(4'd11, 16'h0000);
    wr(4'd15, 16'h0003);
    wr(4'd0, 16'h1300);
    wr(4'd1, 16'h007F);
    qstep(1); qstep(1); qstep(1);
    rd_pos(p);            check("R7 at mod", p, 3);
    qstep(1);
    rd_pos(p);            check("R7 roll over", p, 0);
    rd(4'd1, v);          check("R7 over flag", v[5], 1);
    rd(4'd6, v);          check("R8 rev wrap up", v, 2);
    qstep(0);
    rd_pos(p);            check("R7 roll under", p, 3);
    rd(4'd1, v);          check("R7 under flag", v[6], 1);
    rd(4'd6, v);          check("R8 rev wrap down", v, 1);

    // R11 interrupt
    check("R11 irq masked", irq, 0);
    wr(4'd2, 16'h0020);
    check("R11 irq on", irq, 1);
    wr(4'd1, 16'h0020);
    check("R11 irq cleared", irq, 0);
    rd(4'd1, v);          check("R11 sticky other", v[6], 1);

    // R10 compare match
    wr(4'd12, 16'h0000);
    wr(4'd13, 16'h0002);
    check("R10 no match", pos_match, 0);
    qstep(0);
    check("R10 equal", pos_match, 1);
    rd(4'd1, v);          check("R10 cmp flag", v[3], 1);
    qstep(0);
    check("R10 left", pos_match, 0);
    wr(4'd0, 16'h0700);
    check("R10 read mode idle", pos_match, 0);
    rd(4'd6, v);
    check("R10 read pulse", pos_match, 1);
    @(negedge clk);
    check("R10 pulse ends", pos_match, 0);

    // R12 watchdog
    wr(4'd3, 16'd10);
    wr(4'd0, 16'h0800);
    wr(4'd1, 16'h007F);
    rd(4'd1, v);          check("R12 not yet", v[2], 0);
    repeat (20) @(negedge clk);
    rd(4'd1, v);          check("R12 timeout", v[2], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule